// File: doc/BRIEF.md
# Thread Serial Number Allocator

This block keeps a pool of 28 thread serial numbers that clients claim and give back. Each slot pairs a fixed 8-bit identifier with a single used bit. A claim takes the free slot with the lowest index, marks it used and returns its identifier. When every slot is taken, the claim fails with a busy status.

A give-back names the identifier itself, not the slot index. The block searches for the slot that holds that value and marks it free. The identifiers form a fixed, non-contiguous set that is computed inside the block. Claims use a valid/ready port whose response is registered. Give-backs use a separate port that has a registered error pulse.

Top module: `tsn_pool`

## Requirements
- R1: After reset all 28 slots are free. Slot i holds identifier 0x04 + 8*(i/2) + (i%2) for i/2 < 7, and 0x88 + 16*(i/2 - 7) + (i%2) otherwise. A run of claims from reset therefore returns 0x04, 0x05, 0x0C, ... 0xE8, 0xE9 in slot order.
- R2: A claim takes the lowest-indexed free slot and marks it used. One cycle after the request, rsp_valid_o is 1, rsp_ok_o is 1 and rsp_id_o carries that slot's identifier.
- R3: A claim made when no slot is free gives rsp_ok_o = 0 and rsp_id_o = 0 and changes no slot state.
- R4: A give-back frees the first slot whose identifier equals rel_id_i. That slot is then eligible for later claims.
- R5: A give-back of a value that no slot holds changes no state. It drives rel_err_o high for exactly the one cycle after the request.
- R6: A give-back of an identifier whose slot is already free leaves the slot free and keeps rel_err_o low.
- R7: When a claim and a give-back arrive in the same cycle, the give-back is applied first, so the claim can receive the slot it frees.
- R8: rsp_valid_o is high exactly in the cycle after each accepted claim and low otherwise. alloc_ready_o is always high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Claim request |
| alloc_ready_o | output | 1 | Claim port can accept |
| rsp_valid_o | output | 1 | Claim result present |
| rsp_ok_o | output | 1 | 1 = identifier granted, 0 = pool busy |
| rsp_id_o | output | 8 | Granted identifier, 0 when busy |
| rel_valid_i | input | 1 | Give-back request |
| rel_id_i | input | 8 | Identifier being given back |
| rel_err_o | output | 1 | One-cycle pulse: give-back matched no slot |

## Verification
A corrupted used bit stays hidden until a claim scans that slot. It then shows up as an out-of-order identifier, or as a busy or ok status that the claim history does not explain. That can happen many cycles after the fault. For that reason the bench drains and refills the whole pool, so that every slot is reached by a claim soon after each give-back. A faulty identifier comparator shows up one cycle after the give-back, either as a wrong rel_err_o pulse or as the wrong slot coming back on the next claim. The bench therefore sweeps all 256 give-back values.

// File: rtl/tsn_pkg.sv
package tsn_pkg;
  localparam int unsigned TSN_SLOTS = 28;
  localparam int unsigned TSN_ID_W  = 8;

  typedef logic [TSN_ID_W-1:0] tsn_id_t;

  // fixed identifier of slot i: pairs 04/05 step 08, then pairs 88/89 step 10
  function automatic tsn_id_t tsn_slot_id(int unsigned i);
    int unsigned pair;
    int unsigned val;
    pair = i / 2;
    if (pair < 7) val = 32'h04 + 8 * pair + (i % 2);
    else          val = 32'h88 + 16 * (pair - 7) + (i % 2);
    return tsn_id_t'(val);
  endfunction
endpackage

// File: rtl/tsn_match.sv
module tsn_match #(
  parameter int unsigned N = 28,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0][W-1:0] ids_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        hit_vec_o,
  output logic                hit_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (ids_i[g] == key_i);
  end

  // keep only the first match
  always_comb begin
    logic found;
    found     = 1'b0;
    hit_vec_o = '0;
    for (int k = 0; k < N; k++) begin
      if (eq[k] && !found) begin
        hit_vec_o[k] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/tsn_pick.sv
module tsn_pick #(
  parameter int unsigned N = 28
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !found) begin
        grant_o[k] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/tsn_pool.sv
module tsn_pool
  import tsn_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = TSN_SLOTS,
  parameter int unsigned ID_W      = TSN_ID_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_valid_i,
  output logic            alloc_ready_o,
  output logic            rsp_valid_o,
  output logic            rsp_ok_o,
  output logic [ID_W-1:0] rsp_id_o,
  input  logic            rel_valid_i,
  input  logic [ID_W-1:0] rel_id_i,
  output logic            rel_err_o
);
  localparam int unsigned N = NUM_SLOTS;

  logic [N-1:0][ID_W-1:0] slot_ids;
  logic [N-1:0]           used_q, used_d;
  logic [N-1:0]           rel_hit_vec, rel_clr, free_eff, grant;
  logic                   rel_hit, any_free, alloc_fire, grant_ok;
  logic [ID_W-1:0]        grant_id;

  for (genvar g = 0; g < N; g++) begin : g_ids
    assign slot_ids[g] = ID_W'(tsn_slot_id(g));
  end

  tsn_match #(.N(N), .W(ID_W)) u_match (
    .ids_i     (slot_ids),
    .key_i     (rel_id_i),
    .hit_vec_o (rel_hit_vec),
    .hit_o     (rel_hit)
  );

  assign rel_clr  = rel_valid_i ? rel_hit_vec : '0;
  // release is applied before the allocation scan
  assign free_eff = ~used_q | rel_clr;

  tsn_pick #(.N(N)) u_pick (
    .req_i   (free_eff),
    .grant_o (grant),
    .any_o   (any_free)
  );

  assign alloc_ready_o = 1'b1;
  assign alloc_fire    = alloc_valid_i & alloc_ready_o;
  assign grant_ok      = alloc_fire & any_free;

  always_comb begin
    grant_id = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) grant_id = grant_id | slot_ids[k];
    end
  end

  always_comb begin
    used_d = used_q & ~rel_clr;
    if (grant_ok) used_d = used_d | grant;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_id_o    <= '0;
      rel_err_o   <= 1'b0;
    end else begin
      used_q      <= used_d;
      rsp_valid_o <= alloc_fire;
      rsp_ok_o    <= grant_ok;
      rsp_id_o    <= grant_ok ? grant_id : '0;
      rel_err_o   <= rel_valid_i & ~rel_hit;
    end
  end

  // R2: granted slot is used on the next cycle
  a_r2_grant_marks_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ok |=> ((used_q & $past(grant)) == $past(grant)));

  // R2: grant lies within the free set and is at most one slot
  a_r2_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~free_eff) == '0));

  // R3: busy only when the pool was full, and state is frozen
  a_r3_busy_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ok_o) |-> ($past(&used_q) && $stable(used_q) && rsp_id_o == '0));

  // R5: error pulse traces back to a release that matched nothing
  a_r5_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_err_o |-> ($past(rel_valid_i) && $stable(used_q)));

  // R4: a matching release leaves that slot free unless re-granted at once
  a_r4_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_i && rel_hit && !alloc_valid_i) |=> ((used_q & $past(rel_clr)) == '0));

  // R8: response strobe follows the request by one cycle
  a_r8_rsp_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i |=> rsp_valid_o);
  a_r8_rsp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_valid_i |=> !rsp_valid_o);
endmodule

// File: tb/tsn_pool_test.sv
`timescale 1ns/1ps
module tsn_pool_test;
  localparam int N = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0;
  logic       alloc_ready;
  logic       rsp_valid, rsp_ok, rel_err;
  logic [7:0] rsp_id;
  logic       rel_valid = 1'b0;
  logic [7:0] rel_id = '0;

  int checks = 0;
  int errors = 0;
  bit model_used [N];

  always #2 clk = ~clk;

  tsn_pool uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .rsp_id_o(rsp_id),
    .rel_valid_i(rel_valid), .rel_id_i(rel_id), .rel_err_o(rel_err)
  );

  function automatic logic [7:0] exp_id(int i);
    int p;
    p = i / 2;
    if (p < 7) return 8'(4 + 8 * p + (i % 2));
    return 8'(136 + 16 * (p - 7) + (i % 2));
  endfunction

  // one cycle: drive at negedge, sample at the following negedge
  task automatic do_op(input bit a, input bit r, input logic [7:0] rid, input string tag);
    bit e_valid, e_ok, e_err, found;
    logic [7:0] e_id;
    e_valid = a; e_ok = 0; e_err = 0; e_id = '0; found = 0;
    if (r) begin
      for (int k = 0; k < N; k++)
        if (!found && exp_id(k) == rid) begin model_used[k] = 0; found = 1; end
      e_err = !found;
    end
    if (a) begin
      for (int k = 0; k < N; k++)
        if (!e_ok && !model_used[k]) begin model_used[k] = 1; e_ok = 1; e_id = exp_id(k); end
    end
    alloc_valid = a; rel_valid = r; rel_id = rid;
    @(negedge clk);
    alloc_valid = 0; rel_valid = 0; rel_id = '0;
    checks++;
    if (rsp_valid !== e_valid || rsp_ok !== e_ok || rsp_id !== e_id || rel_err !== e_err || alloc_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s: got v=%b ok=%b id=%h err=%b rdy=%b, expected v=%b ok=%b id=%h err=%b rdy=1",
               tag, rsp_valid, rsp_ok, rsp_id, rel_err, alloc_ready, e_valid, e_ok, e_id, e_err);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) model_used[k] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rel_err !== 0 || rsp_ok !== 0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b ok=%b err=%b, expected 0 0 0", rsp_valid, rsp_ok, rel_err);
    end
    rst_n = 1'b1;
    @(negedge clk);
    do_op(0, 0, 8'h00, "R8 idle");

    for (int k = 0; k < N; k++) do_op(1, 0, 8'h00, "R1 R2 fill order");
    for (int k = 0; k < 3; k++) do_op(1, 0, 8'h00, "R3 busy");

    for (int k = 0; k < N; k++) begin
      do_op(0, 1, exp_id(k), "R4 release");
      do_op(0, 0, 8'h00, "R5 no err pulse");
      do_op(1, 0, 8'h00, "R2 R4 regrant");
      do_op(1, 0, 8'h00, "R3 stays full");
    end

    do_op(0, 1, exp_id(10), "R4 release");
    do_op(0, 1, exp_id(2), "R4 release");
    do_op(1, 0, 8'h00, "R2 lowest first");
    do_op(1, 0, 8'h00, "R2 next lowest");
    do_op(1, 0, 8'h00, "R3 busy again");

    do_op(1, 1, exp_id(5), "R7 release then grant");
    do_op(1, 1, 8'h00, "R5 R7 unknown with claim");
    do_op(0, 0, 8'h00, "R5 pulse width");

    for (int v = 0; v < 256; v++) begin
      do_op(0, 1, 8'(v), "R4 R5 value sweep");
      do_op(0, 0, 8'h00, "R5 pulse width");
    end

    for (int k = N - 1; k >= 0; k--) do_op(0, 1, exp_id(k), "R6 free again");
    for (int k = 0; k < N; k++) do_op(1, 0, 8'h00, "R6 R1 order kept");
    do_op(1, 0, 8'h00, "R3 busy");
    do_op(0, 0, 8'h00, "R8 quiet");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule